// File: doc/BRIEF.md
# Fixed-Point RGB to YUV Pixel Converter

This block turns one pixel of 8-bit red, green and blue components into 8-bit luma (Y) and two chroma (U, V) values. It uses fixed integer weights scaled by 2^13. The caller presents a pixel with `in_valid` high. Exactly two clock edges later the converted pixel appears with `out_valid` high. A new pixel may be presented on every cycle.

Each channel goes through a two-stage pipeline. The first stage computes a signed weighted sum of the three components. The second stage shifts that sum arithmetically right by 13 bits, adds the channel offset (16 for luma, 128 for chroma) and clamps the result to the 8-bit range.

Alongside the pipeline sit three border-colour registers, one for each of Y, U and V. They come out of reset holding YUV black and can be rewritten one at a time through a small write port.

Top module: `rgb2yuv_conv`

## Requirements
- R1: Luma: out_y = 16 + ((2104·R + 4130·G + 802·B) >> 13).
- R2: U chroma: out_u = 128 + ((3598·B − 1217·R − 2382·G) >>> 13). The sum is signed and the shift is arithmetic, rounding toward negative infinity.
- R3: V chroma: out_v = 128 + ((3598·R − 3015·G − 583·B) >>> 13). The sum is signed and the shift is arithmetic.
- R4: A pixel accepted on a clock edge with in_valid high appears with out_valid high after the second edge that follows. Back-to-back inputs give back-to-back outputs, and out_valid is never high without such an input.
- R5: Every result is clamped to 0..255. For any 8-bit input this leaves out_y in 16..235 and out_u and out_v in 15..240.
- R6: While rst is high on a clock edge, both pipeline valid bits and the output data registers clear to zero.
- R7: Reset loads the border registers with bord_y = 0x10, bord_u = 0x80 and bord_v = 0x80.
- R8: A write with bord_we high loads bord_data into the register chosen by bord_sel: 0 selects Y, 1 selects U, 2 selects V. Selector value 3 changes none of the three.
- R9: out_y, out_u and out_v keep their last values while no new result is produced.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input pixel strobe |
| in_r | input | 8 | Red component |
| in_g | input | 8 | Green component |
| in_b | input | 8 | Blue component |
| out_valid | output | 1 | Result strobe, two cycles after in_valid |
| out_y | output | 8 | Luma result |
| out_u | output | 8 | U chroma result |
| out_v | output | 8 | V chroma result |
| bord_we | input | 1 | Border register write enable |
| bord_sel | input | 2 | Border register select (0 Y, 1 U, 2 V, 3 none) |
| bord_data | input | 8 | Border write data |
| bord_y | output | 8 | Border luma |
| bord_u | output | 8 | Border U chroma |
| bord_v | output | 8 | Border V chroma |

## Verification
The range assertions on the accumulators and the converted outputs take for granted that every component is an unsigned 8-bit value. Under that assumption the weighted sums stay within ±2^21, and the clamp never needs to act. The latency assertion assumes in_valid is held low during reset, and the bench drives it low for the whole reset period. The stimulus stays inside these limits and still reaches the extremes of both chroma sums: pure blue and yellow for U, pure red and cyan for V, plus black and white, mixed with pseudo-random pixels sent in bursts and with gaps.

// File: rtl/rgb2yuv_pkg.sv
package rgb2yuv_pkg;

    localparam int PIX_W   = 8;
    localparam int FRAC    = 13;
    localparam int ACC_W   = PIX_W + 16;
    localparam int NCH     = 3;
    localparam int PIX_MAX = (1 << PIX_W) - 1;

    typedef logic [PIX_W-1:0]        pix_t;
    typedef logic signed [ACC_W-1:0] acc_t;

    typedef enum logic [1:0] {
        CH_Y    = 2'd0,
        CH_U    = 2'd1,
        CH_V    = 2'd2,
        CH_NONE = 2'd3
    } chan_e;

    typedef struct packed {
        pix_t r;
        pix_t g;
        pix_t b;
    } rgb_t;

    // weight of component k (0 red, 1 green, 2 blue) for output channel ch
    function automatic acc_t weight(int ch, int k);
        int w;
        case (ch)
            0:       w = (k == 0) ?  2104 : (k == 1) ?  4130 :  802;
            1:       w = (k == 0) ? -1217 : (k == 1) ? -2382 : 3598;
            default: w = (k == 0) ?  3598 : (k == 1) ? -3015 : -583;
        endcase
        return acc_t'(w);
    endfunction

    function automatic acc_t bias(int ch);
        return (ch == 0) ? acc_t'(16) : acc_t'(128);
    endfunction

    function automatic acc_t widen(pix_t p);
        return $signed({{(ACC_W-PIX_W){1'b0}}, p});
    endfunction

    function automatic pix_t clamp(acc_t v);
        if (v < 0)
            return '0;
        else if (v > acc_t'(PIX_MAX))
            return pix_t'(PIX_MAX);
        else
            return v[PIX_W-1:0];
    endfunction

endpackage

// File: rtl/rgb2yuv_mac.sv
module rgb2yuv_mac
    import rgb2yuv_pkg::*;
#(
    parameter int CH = 0
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  rgb_t pix,
    output acc_t acc
);
    localparam acc_t WR = weight(CH, 0);
    localparam acc_t WG = weight(CH, 1);
    localparam acc_t WB = weight(CH, 2);
    localparam int   BOUND = 1 << (ACC_W - 3);

    acc_t sum;

    always_comb begin
        sum = WR * widen(pix.r) + WG * widen(pix.g) + WB * widen(pix.b);
    end

    always_ff @(posedge clk) begin
        if (rst)
            acc <= '0;
        else if (en)
            acc <= sum;
    end

    // R5: an 8-bit pixel keeps every weighted sum far inside the accumulator
    assert_acc_bound_R5: assert property (@(posedge clk) disable iff (rst)
        en |=> (acc < acc_t'(BOUND)) && (acc > -acc_t'(BOUND)));

endmodule

// File: rtl/rgb2yuv_scale.sv
module rgb2yuv_scale
    import rgb2yuv_pkg::*;
#(
    parameter int CH = 0
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  acc_t acc,
    output pix_t res
);
    localparam pix_t LO = (CH == 0) ? pix_t'(16)  : pix_t'(15);
    localparam pix_t HI = (CH == 0) ? pix_t'(235) : pix_t'(240);

    acc_t shifted;
    acc_t offset;

    always_comb begin
        shifted = acc >>> FRAC;
        offset  = shifted + bias(CH);
    end

    always_ff @(posedge clk) begin
        if (rst)
            res <= '0;
        else if (en)
            res <= clamp(offset);
    end

    // R5: the output of an 8-bit pixel stays in the channel's range
    assert_out_range_R5: assert property (@(posedge clk) disable iff (rst)
        en |=> (res >= LO) && (res <= HI));

    // R9: the result register holds when no new result is loaded
    assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(res));

endmodule

// File: rtl/rgb2yuv_border.sv
module rgb2yuv_border
    import rgb2yuv_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  we,
    input  chan_e sel,
    input  pix_t  wdata,
    output pix_t  y,
    output pix_t  u,
    output pix_t  v
);
    localparam pix_t BLACK_Y = pix_t'(16);
    localparam pix_t BLACK_C = pix_t'(128);

    always_ff @(posedge clk) begin
        if (rst) begin
            y <= BLACK_Y;
            u <= BLACK_C;
            v <= BLACK_C;
        end else if (we) begin
            case (sel)
                CH_Y:    y <= wdata;
                CH_U:    u <= wdata;
                CH_V:    v <= wdata;
                default: ;
            endcase
        end
    end

    // R7: values right after reset are YUV black
    assert_border_reset_R7: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (y == 8'h10) && (u == 8'h80) && (v == 8'h80));

    // R8: a luma write lands in the luma register
    assert_border_wr_y_R8: assert property (@(posedge clk) disable iff (rst)
        (we && sel == CH_Y) |=> (y == $past(wdata)));

    // R8: the unused selector leaves all three registers alone
    assert_border_none_R8: assert property (@(posedge clk) disable iff (rst)
        (we && sel == CH_NONE) |=> ($stable(y) && $stable(u) && $stable(v)));

endmodule

// File: rtl/rgb2yuv_conv.sv
module rgb2yuv_conv
    import rgb2yuv_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       in_valid,
    input  logic [7:0] in_r,
    input  logic [7:0] in_g,
    input  logic [7:0] in_b,
    output logic       out_valid,
    output logic [7:0] out_y,
    output logic [7:0] out_u,
    output logic [7:0] out_v,
    input  logic       bord_we,
    input  logic [1:0] bord_sel,
    input  logic [7:0] bord_data,
    output logic [7:0] bord_y,
    output logic [7:0] bord_u,
    output logic [7:0] bord_v
);
    rgb_t pix_in;
    acc_t acc [NCH];
    pix_t res [NCH];
    logic s1_valid;
    logic s2_valid;

    assign pix_in = '{r: in_r, g: in_g, b: in_b};

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_valid <= 1'b0;
            s2_valid <= 1'b0;
        end else begin
            s1_valid <= in_valid;
            s2_valid <= s1_valid;
        end
    end

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        rgb2yuv_mac #(.CH(c)) u_mac (
            .clk (clk),
            .rst (rst),
            .en  (in_valid),
            .pix (pix_in),
            .acc (acc[c])
        );
        rgb2yuv_scale #(.CH(c)) u_scale (
            .clk (clk),
            .rst (rst),
            .en  (s1_valid),
            .acc (acc[c]),
            .res (res[c])
        );
    end

    assign out_valid = s2_valid;
    assign out_y     = res[0];
    assign out_u     = res[1];
    assign out_v     = res[2];

    rgb2yuv_border u_border (
        .clk   (clk),
        .rst   (rst),
        .we    (bord_we),
        .sel   (chan_e'(bord_sel)),
        .wdata (bord_data),
        .y     (bord_y),
        .u     (bord_u),
        .v     (bord_v)
    );

    // R4: every result is the image of an input two edges earlier
    assert_latency_R4: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(in_valid, 2));

    // R4: every accepted input produces a result two edges later
    assert_no_drop_R4: assert property (@(posedge clk) disable iff (rst)
        s1_valid |=> out_valid);

endmodule

// File: tb/rgb2yuv_conv_test.sv
module rgb2yuv_conv_test;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 50000;

    typedef struct {
        int y;
        int u;
        int v;
        int due;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic [7:0] in_r = '0, in_g = '0, in_b = '0;
    logic       out_valid;
    logic [7:0] out_y, out_u, out_v;
    logic       bord_we = 1'b0;
    logic [1:0] bord_sel = '0;
    logic [7:0] bord_data = '0;
    logic [7:0] bord_y, bord_u, bord_v;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 1'b0;
    bit have_last = 1'b0;
    int last_y, last_u, last_v;
    exp_t sb[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    rgb2yuv_conv uut (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .in_r(in_r), .in_g(in_g), .in_b(in_b),
        .out_valid(out_valid), .out_y(out_y), .out_u(out_u), .out_v(out_v),
        .bord_we(bord_we), .bord_sel(bord_sel), .bord_data(bord_data),
        .bord_y(bord_y), .bord_u(bord_u), .bord_v(bord_v)
    );

    always @(posedge clk) cyc <= cyc + 1;

    function automatic int sat(int x);
        return (x < 0) ? 0 : (x > 255) ? 255 : x;
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic send(int r, int g, int b);
        exp_t e;
        @(negedge clk);
        in_valid = 1'b1;
        in_r = 8'(r); in_g = 8'(g); in_b = 8'(b);
        e.y = sat(16  + ((2104*r + 4130*g + 802*b) >>> 13));
        e.u = sat(128 + ((3598*b - 1217*r - 2382*g) >>> 13));
        e.v = sat(128 + ((3598*r - 3015*g - 583*b) >>> 13));
        e.due = cyc + 2;
        sb.push_back(e);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    task automatic bwrite(int sel, int d);
        @(negedge clk);
        bord_we = 1'b1; bord_sel = 2'(sel); bord_data = 8'(d);
        @(negedge clk);
        bord_we = 1'b0;
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (!rst && !done) begin
            if (out_valid) begin
                if (sb.size() == 0) begin
                    check(1'b0, "R4 spurious out_valid", 1, 0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    check(cyc == e.due, "R4 latency", cyc, e.due);
                    check(int'(out_y) == e.y, "R1 luma", out_y, e.y);
                    check(int'(out_u) == e.u, "R2 U chroma", out_u, e.u);
                    check(int'(out_v) == e.v, "R3 V chroma", out_v, e.v);
                    check(out_y >= 16 && out_y <= 235, "R5 luma range", out_y, 16);
                    check(out_u >= 15 && out_u <= 240 && out_v >= 15 && out_v <= 240,
                          "R5 chroma range", out_u, 128);
                    last_y = out_y; last_u = out_u; last_v = out_v;
                    have_last = 1'b1;
                end
            end else if (have_last) begin
                check(int'(out_y) == last_y && int'(out_u) == last_u && int'(out_v) == last_v,
                      "R9 hold", out_y, last_y);
            end
        end
    end

    // watchdog
    always @(posedge clk) begin
        if (cyc == WATCHDOG && !done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected<%0d", cyc, WATCHDOG);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R6 / R7: reset state
        check(out_valid == 1'b0, "R6 valid after reset", out_valid, 0);
        check(out_y == 0 && out_u == 0 && out_v == 0, "R6 data after reset", out_y, 0);
        check(bord_y == 8'h10, "R7 border Y", bord_y, 16);
        check(bord_u == 8'h80, "R7 border U", bord_u, 128);
        check(bord_v == 8'h80, "R7 border V", bord_v, 128);

        // corner colours, back to back (R1 R2 R3 R4)
        send(0, 0, 0);
        send(255, 255, 255);
        send(255, 0, 0);
        send(0, 255, 0);
        send(0, 0, 255);
        send(255, 255, 0);   // most negative U sum
        send(0, 255, 255);   // most negative V sum
        send(255, 0, 255);
        idle(4);

        // single pixels with gaps (R4 R9)
        for (int i = 0; i < 10; i++) begin
            send((i * 37) & 255, (i * 91) & 255, (i * 13 + 7) & 255);
            idle(1 + (i % 3));
        end

        // pseudo-random bursts
        for (int i = 0; i < 300; i++) begin
            send($urandom_range(0, 255), $urandom_range(0, 255), $urandom_range(0, 255));
            if (i % 17 == 16) idle(2);
        end
        idle(5);
        check(sb.size() == 0, "R4 all results delivered", sb.size(), 0);

        // border writes (R8)
        bwrite(0, 8'h55);
        check(bord_y == 8'h55, "R8 write Y", bord_y, 8'h55);
        bwrite(1, 8'h21);
        check(bord_u == 8'h21, "R8 write U", bord_u, 8'h21);
        bwrite(2, 8'hC3);
        check(bord_v == 8'hC3, "R8 write V", bord_v, 8'hC3);
        bwrite(3, 8'hAA);
        check(bord_y == 8'h55 && bord_u == 8'h21 && bord_v == 8'hC3,
              "R8 selector 3 ignored", bord_y, 8'h55);

        // reset during traffic clears pipeline (R6)
        send(10, 20, 30);
        @(negedge clk);
        in_valid = 1'b0;
        rst = 1'b1;
        sb.delete();
        have_last = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        check(out_valid == 1'b0, "R6 valid cleared", out_valid, 0);
        check(bord_y == 8'h10, "R7 border Y reloaded", bord_y, 16);
        @(negedge clk);
        check(out_valid == 1'b0, "R6 no stale result", out_valid, 0);
        idle(2);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule